// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block turns the functional clock into the edge ticks that pace a half-duplex serial master. A global first stage divides the functional clock by 2, 4, 7 or 10. Its output feeds a second stage that divides by 2, 4 or 8. The second-stage ratio comes from the mode field of whichever chip select is active. The result is a one-cycle tick at twice the serial clock rate, so there is one tick for each serial clock edge, together with the current level of the serial clock phase. The shift logic uses the ticks to decide when to launch and capture data bits.

The first-stage selector and the module enable share one small configuration word. The second-stage code is read straight from the active device's mode field. The first-stage ratio is shared by every device, so the controller reloads it whenever it changes device. A restart pulse at the start of each transfer clears both counters, which gives every transfer the same distance from start to first edge. When the enable bit is cleared, the block goes quiet and clears its counters.

Top module: `sclk_div_gen`

## Requirements
- R1: After reset, `edge_tick` and `sclk_phase` are 0.
- R2: `cfg_word[2:1]` selects the first-stage ratio: value 0 divides by 2, 1 by 4, 2 by 7, 3 by 10.
- R3: `mode_field[4:3]` selects the second-stage ratio: code 00 divides by 2, 01 by 4, 10 by 8.
- R4: Code 11 in `mode_field[4:3]` divides by 8, the same as code 10.
- R5: While enabled, consecutive ticks are spaced N = (first ratio × second ratio)/2 cycles apart. The slowest setting (10 and 8) gives a tick every 40 cycles, which is a serial clock of the functional clock divided by 80.
- R6: `sclk_phase` toggles in the same cycle as each tick and holds its value between ticks.
- R7: A clock edge that samples `restart` high clears both counters, `edge_tick` and `sclk_phase`. The first tick then appears at the N-th clock edge after that edge.
- R8: While `cfg_word[0]` (enable) is 0, no tick is produced and `sclk_phase` stays 0. When enable rises without a restart, the first tick appears at the N-th edge, counting the first edge that samples enable high.
- R9: `mode_field` bits 5 and 2:0 have no effect on the tick spacing.
- R10: Each tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 3 | Bit 0 is the module enable; bits 2:1 are the first-stage ratio index |
| mode_field | input | 6 | Mode field of the active chip select; bits 4:3 are the second-stage code |
| restart | input | 1 | Synchronous counter clear at transfer start |
| edge_tick | output | 1 | One-cycle pulse for each serial clock edge |
| sclk_phase | output | 1 | Current serial clock level, toggled on each tick |

## Verification
The bench measures the distance from restart to the first tick and from the first tick to the second for eight ratio pairs. These include the odd divide-by-7 stage, where a counter reloading at the wrong value would stretch or shrink every edge by a cycle. It also covers the slowest divide-by-80 setting, where a counter that is too narrow would wrap early. Code 11 is tested separately, because a design that decodes it as divide by 2 gives ticks four times too fast. A run with the other mode bits set would catch a decode that reads the wrong field. The enable test holds the block off for 50 cycles and then releases it. A design that kept counting while off would tick on the first enabled cycles, and one that left the phase dirty would show a high phase.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    typedef enum logic [1:0] {
        POST_BY2  = 2'b00,
        POST_BY4  = 2'b01,
        POST_BY8  = 2'b10,
        POST_BY8X = 2'b11
    } post_code_e;

    // Number of first-stage pulses between two serial clock edges
    // (half of the second-stage ratio).
    function automatic logic [2:0] post_half(input post_code_e code);
        case (code)
            POST_BY2: post_half = 3'd1;
            POST_BY4: post_half = 3'd2;
            default:  post_half = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
    parameter int unsigned DIV0 = 2,
    parameter int unsigned DIV1 = 4,
    parameter int unsigned DIV2 = 7,
    parameter int unsigned DIV3 = 10,
    localparam int unsigned DMAX01 = (DIV0 > DIV1) ? DIV0 : DIV1,
    localparam int unsigned DMAX23 = (DIV2 > DIV3) ? DIV2 : DIV3,
    localparam int unsigned DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23,
    localparam int unsigned CW     = $clog2(DMAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       hit_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (sel_i)
            2'd0:    lim = CW'(DIV0);
            2'd1:    lim = CW'(DIV1);
            2'd2:    lim = CW'(DIV2);
            default: lim = CW'(DIV3);
        endcase
        st_d  = st_q;
        hit_o = 1'b0;
        if (!en_i || restart_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim - CW'(1)) begin
            st_d.cnt = '0;
            hit_o    = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the count never leaves the range of the largest ratio
    p_pre_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(DMAX));

    // R8: a disabled prescaler sits at zero
    p_pre_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> st_q.cnt == '0);

endmodule

// File: rtl/sclk_postscaler.sv
module sclk_postscaler
    import sclk_div_pkg::*;
#(
    parameter int unsigned MAX_HALF = 4,
    localparam int unsigned PW = $clog2(MAX_HALF + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       restart_i,
    input  logic       hit_i,
    input  logic [1:0] code_i,
    output logic       tick_o,
    output logic       phase_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          tick;
        logic          phase;
    } post_st_t;

    post_st_t      st_d, st_q;
    logic [PW-1:0] half;

    always_comb begin
        half       = PW'(post_half(post_code_e'(code_i)));
        st_d       = st_q;
        st_d.tick  = 1'b0;
        if (!en_i || restart_i) begin
            st_d.cnt   = '0;
            st_d.phase = 1'b0;
        end else if (hit_i) begin
            if (st_q.cnt >= half - PW'(1)) begin
                st_d.cnt   = '0;
                st_d.tick  = 1'b1;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o  = st_q.tick;
    assign phase_o = st_q.phase;

    p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> phase_o != $past(phase_o));

    p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o && !phase_o);

    p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o && !phase_o);

endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen #(
    parameter int unsigned DIV0     = 2,
    parameter int unsigned DIV1     = 4,
    parameter int unsigned DIV2     = 7,
    parameter int unsigned DIV3     = 10,
    parameter int unsigned MAX_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cfg_word,
    input  logic [5:0] mode_field,
    input  logic       restart,
    output logic       edge_tick,
    output logic       sclk_phase
);

    logic en;
    logic pre_hit;

    assign en = cfg_word[0];

    sclk_prescaler #(
        .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .restart_i (restart),
        .sel_i     (cfg_word[2:1]),
        .hit_o     (pre_hit)
    );

    sclk_postscaler #(
        .MAX_HALF(MAX_HALF)
    ) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .restart_i (restart),
        .hit_i     (pre_hit),
        .code_i    (mode_field[4:3]),
        .tick_o    (edge_tick),
        .phase_o   (sclk_phase)
    );

    // R5: a tick is only ever launched by a first-stage pulse
    p_tick_from_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |-> $past(pre_hit));

endmodule

// File: tb/sclk_div_gen_test.sv
module sclk_div_gen_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_word = 3'b000;
    logic [5:0] mode_field = 6'b0;
    logic       restart = 1'b0;
    logic       edge_tick;
    logic       sclk_phase;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_div_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .mode_field (mode_field),
        .restart    (restart),
        .edge_tick  (edge_tick),
        .sclk_phase (sclk_phase)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts negedges until a tick is seen; returns 999 on timeout.
    task automatic count_to_tick(output int n);
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (edge_tick) return;
        end
        n = 999;
    endtask

    task automatic run_case(input logic [1:0] idx, input logic [5:0] mode,
                            input int n_exp, input string tag);
        int n;
        @(negedge clk);
        cfg_word   = {idx, 1'b1};
        mode_field = mode;
        restart    = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check(!edge_tick && !sclk_phase, {tag, " R7 cleared after restart"},
              int'({edge_tick, sclk_phase}), 0);
        count_to_tick(n);
        check(n == n_exp, {tag, " R5 R7 first tick distance"}, n, n_exp);
        check(sclk_phase == 1'b1, {tag, " R6 phase after first tick"}, sclk_phase, 1);
        count_to_tick(n);
        check(n == n_exp, {tag, " R5 second tick distance"}, n, n_exp);
        check(sclk_phase == 1'b0, {tag, " R6 phase after second tick"}, sclk_phase, 0);
        @(negedge clk);
        check(!edge_tick, {tag, " R10 tick lasts one cycle"}, edge_tick, 0);
    endtask

    task automatic test_reset();
        check(!edge_tick && !sclk_phase, "R1 reset state",
              int'({edge_tick, sclk_phase}), 0);
    endtask

    task automatic test_enable();
        int n;
        int seen = 0;
        @(negedge clk);
        cfg_word   = 3'b011;
        mode_field = 6'b001000;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (edge_tick || sclk_phase) seen++;
            cfg_word[0] = 1'b0;
        end
        check(seen == 0, "R8 silent while disabled", seen, 0);
        cfg_word[0] = 1'b1;
        count_to_tick(n);
        check(n == 8, "R8 first tick after enable", n, 8);
        check(sclk_phase == 1'b1, "R8 R6 phase after enable tick", sclk_phase, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_case(2'd0, 6'b000000,  2, "R2 R3 div2x2");
        run_case(2'd1, 6'b001000,  8, "R2 R3 div4x4");
        run_case(2'd2, 6'b000000,  7, "R2 div7x2");
        run_case(2'd2, 6'b001000, 14, "R2 R3 div7x4");
        run_case(2'd1, 6'b010000, 16, "R3 div4x8");
        run_case(2'd3, 6'b010000, 40, "R2 R5 div10x8");
        run_case(2'd3, 6'b011000, 40, "R4 code11");
        run_case(2'd0, 6'b101111,  4, "R9 other mode bits");
        test_enable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule